// File: doc/BRIEF.md
# Start-Stop Time Interval Gate

This block produces the counting window for a time interval measurement that a channel A event starts and a channel B event stops. The first accepted channel A trigger sets a start stage, and the gate opens. Setting the start stage arms a stop stage. Channel B triggers have no effect until that happens. The first channel B trigger after arming sets the stop stage, and the gate closes. While the gate output is high, an external counter accumulates reference clock pulses. The counter, the reference clock and any display are outside this block.

The trigger inputs are single-cycle pulses that are already synchronous to `clk`. The block acts only while `mode_en` is high. When `mode_en` is low, both stages are held idle and the gate stays closed. A `clr` pulse idles the start stage, and idling the start stage also idles the stop stage. After a measurement completes, the block holds its closed state until it is cleared. A one-cycle `done` pulse marks the closing of the gate.

Top module: `ab_interval_gate`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `gate_open` and `done` are both 0.
- R2: With `mode_en` high and the block idle, a `trig_a` pulse sampled at a clock edge drives `gate_open` to 1 from that edge onward.
- R3: A `trig_b` pulse that arrives while the block is idle (not yet started) is ignored: `gate_open` stays 0, `done` stays 0, and a later `trig_a` still opens the gate.
- R4: While the gate is open, a `trig_b` pulse sampled at a clock edge drives `gate_open` to 0 from that edge onward.
- R5: `done` is 1 for exactly one cycle, and only in the cycle right after the edge at which the gate closed because of a stop event.
- R6: Further `trig_a` pulses while the gate is open have no effect, and the gate stays open.
- R7: A `clr` pulse returns the block to idle at the next edge. `clr` takes priority over triggers on the same edge, and clearing never produces `done`. After a clear, the next `trig_a` opens the gate again.
- R8: While `mode_en` is low, `gate_open` is 0 and triggers are ignored. Dropping `mode_en` during a measurement returns the block to idle without a `done` pulse.
- R9: If `trig_a` and `trig_b` are sampled at the same edge while the block is idle, `gate_open` is 1 for exactly one cycle, and `done` follows in the next cycle.
- R10: After a measurement completes, `trig_a` and `trig_b` are ignored until `clr` is applied: the gate stays closed and `done` does not repeat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_en | input | 1 | High selects A-start/B-stop interval operation |
| clr | input | 1 | Synchronous clear pulse that returns the block to idle |
| trig_a | input | 1 | Channel A (start) trigger pulse |
| trig_b | input | 1 | Channel B (stop) trigger pulse |
| gate_open | output | 1 | High while the counting window is open |
| done | output | 1 | One-cycle pulse when the window closes on a stop event |

## Verification
On every cycle, the assertions check the following invariants:
- the gate only rises after an accepted A trigger;
- the stop stage only sets while it is armed;
- `done` is a single cycle that coincides with a closing gate;
- the gate is closed one edge after a clear or after the mode is disabled.

Some behaviours need a sequence of stimulus and only the bench scenarios show them:
- an early B trigger is harmlessly discarded and the next A still works;
- coincident A and B give a gate exactly one cycle wide;
- the completed state stays held against further triggers until a clear;
- a clear during the coincident-trigger window suppresses `done`.

// File: rtl/ab_gate_pkg.sv
package ab_gate_pkg;
  // Control handed from the start stage to the stop stage.
  typedef struct packed {
    logic kill;      // both stages forced idle this edge
    logic armed;     // start stage is set, stop stage may act
    logic coincide;  // start accepted with a stop trigger on the same edge
  } start_ctl_t;
endpackage

// File: rtl/ab_gate_start.sv
module ab_gate_start
  import ab_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_en,
  input  logic       clr,
  input  logic       trig_a,
  input  logic       trig_b,
  output logic       started,
  output start_ctl_t ctl
);
  logic started_q, started_d, started_en;
  logic kill, take_a;

  always_comb begin
    kill       = clr | ~mode_en;
    take_a     = trig_a & ~started_q & ~kill;
    started_en = take_a | kill;
    started_d  = kill ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          started_q <= 1'b0;
    else if (started_en) started_q <= started_d;
  end

  assign started      = started_q;
  assign ctl.kill     = kill;
  assign ctl.armed    = started_q;
  assign ctl.coincide = take_a & trig_b;

  AST_START_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && mode_en && !clr) |=> started_q); // R6
  AST_START_KILLED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr || !mode_en) |=> !started_q); // R7
endmodule

// File: rtl/ab_gate_stop.sv
module ab_gate_stop
  import ab_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  start_ctl_t ctl,
  input  logic       trig_b,
  output logic       stopped,
  output logic       stop_rise
);
  logic stop_q, stop_d;
  logic pend_q, pend_d;
  logic idle_req, armed_w;

  always_comb begin
    armed_w  = ctl.armed;
    idle_req = ~ctl.armed | ctl.kill;
    pend_d   = ctl.coincide;
    if (idle_req) stop_d = 1'b0;
    else          stop_d = stop_q | trig_b | pend_q;
    stop_rise = stop_d & ~stop_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      stop_q <= stop_d;
      pend_q <= pend_d;
    end
  end

  assign stopped = stop_q;

  AST_STOP_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_q) |-> $past(armed_w)); // R3
  AST_PEND_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> !pend_q); // R9
endmodule

// File: rtl/ab_gate_done.sv
module ab_gate_done (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_rise,
  output logic done
);
  logic done_q, done_d;

  always_comb done_d = stop_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign done = done_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R5
endmodule

// File: rtl/ab_interval_gate.sv
module ab_interval_gate
  import ab_gate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_en,
  input  logic clr,
  input  logic trig_a,
  input  logic trig_b,
  output logic gate_open,
  output logic done
);
  start_ctl_t ctl;
  logic started, stopped, stop_rise;

  ab_gate_start u_start (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .clr(clr),
    .trig_a(trig_a), .trig_b(trig_b), .started(started), .ctl(ctl)
  );

  ab_gate_stop u_stop (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .trig_b(trig_b),
    .stopped(stopped), .stop_rise(stop_rise)
  );

  ab_gate_done u_done (
    .clk(clk), .rst_n(rst_n), .stop_rise(stop_rise), .done(done)
  );

  assign gate_open = started & ~stopped;

  AST_OPEN_FROM_A: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_open) |-> ($past(trig_a) && $past(mode_en))); // R2
  AST_DONE_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!gate_open && $past(gate_open))); // R5
  AST_MODE_OFF_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> !gate_open); // R8
  AST_CLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!gate_open && !done)); // R7
endmodule

// File: tb/ab_interval_gate_tb.sv
module ab_interval_gate_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_en = 1'b0, clr = 1'b0, trig_a = 1'b0, trig_b = 1'b0;
  logic gate_open, done;

  int total = 0;
  int bad = 0;
  string req = "R1";
  bit model_on = 1'b0;

  // behavioural reference: 0 idle, 1 open, 2 open with stop pending, 3 closed
  int m_state = 0;
  bit m_done = 1'b0;

  always #4 clk = ~clk;

  ab_interval_gate u_dut (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .clr(clr),
    .trig_a(trig_a), .trig_b(trig_b), .gate_open(gate_open), .done(done)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state <= 0;
      m_done  <= 1'b0;
    end else begin
      m_done <= 1'b0;
      if (!mode_en || clr) m_state <= 0;
      else begin
        case (m_state)
          0: if (trig_a) m_state <= trig_b ? 2 : 1;
          1: if (trig_b) begin m_state <= 3; m_done <= 1'b1; end
          2: begin m_state <= 3; m_done <= 1'b1; end
          default: m_state <= 3;
        endcase
      end
    end
  end

  task automatic check(input string r, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", r, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_on) begin
      check(req, gate_open, (m_state == 1 || m_state == 2), "gate_open");
      check(req, done, m_done, "done");
    end
  end

  task automatic cyc(input bit m, input bit c, input bit a, input bit b);
    @(negedge clk);
    mode_en = m; clr = c; trig_a = a; trig_b = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(mode_en, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin : watchdog
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: outputs quiet in reset
    repeat (3) @(negedge clk);
    check("R1", gate_open, 1'b0, "gate_open in reset");
    check("R1", done, 1'b0, "done in reset");
    rst_n = 1'b1;
    model_on = 1'b1;
    idle(2);
    // R8: mode off, triggers ignored
    req = "R8";
    cyc(0, 0, 1, 0); cyc(0, 0, 0, 1); cyc(0, 0, 1, 1); idle(2);
    // R3: early B ignored
    req = "R3";
    cyc(1, 0, 0, 1); cyc(1, 0, 0, 0); cyc(1, 0, 0, 1); idle(2);
    // R2 open, R6 extra A ignored
    req = "R2"; cyc(1, 0, 1, 0); idle(3);
    req = "R6"; cyc(1, 0, 1, 0); idle(1); cyc(1, 0, 1, 0); idle(2);
    // R4/R5 close with done
    req = "R4"; cyc(1, 0, 0, 1);
    req = "R5"; idle(3);
    // R10 held closed
    req = "R10";
    cyc(1, 0, 1, 0); cyc(1, 0, 0, 1); cyc(1, 0, 1, 1); idle(3);
    // R7 clear then reopen, clear while open, clear beats A
    req = "R7";
    cyc(1, 1, 0, 0); idle(2);
    cyc(1, 0, 1, 0); idle(2);
    cyc(1, 1, 0, 0); idle(2);
    cyc(1, 1, 1, 0); idle(2);
    cyc(1, 1, 1, 1); idle(2);
    // R9 coincident triggers
    req = "R9";
    cyc(1, 0, 1, 1); idle(4);
    cyc(1, 1, 0, 0); idle(1);
    // R7 clear in the coincident window suppresses done
    req = "R7";
    cyc(1, 0, 1, 1); cyc(1, 1, 0, 0); idle(3);
    // R8 mode dropped mid-measurement, then restored
    req = "R8";
    cyc(1, 0, 1, 0); idle(2); cyc(0, 0, 0, 0); idle(2);
    cyc(0, 0, 0, 1); idle(1);
    cyc(1, 0, 0, 1); idle(1);
    req = "R2"; cyc(1, 0, 1, 0); idle(2);
    req = "R4"; cyc(1, 0, 0, 1); idle(3);
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule